// File: doc/BRIEF.md
# Flash Program/Erase Interlock Controller

This block holds the control word that governs program and erase operations on an embedded flash array and enforces the software and hardware interlocks around the high-voltage pulse. Software writes the control word through a simple register port. A snoop port watches bus writes that land in the array address range. During an active erase sequence, any such write counts as the interlock write. During an active program sequence, such writes are steered into page-buffer slots.

The high-voltage enable can only be raised once a sequence is active and a qualifying array write has been seen since that sequence began. While the enable is up, the sequence bit is frozen, programming writes are dropped and array reads are refused. An asynchronous master reset clears the whole control word. A synchronous system reset or the stop input drops only the high-voltage enable. The pulse request leaving the block is the enable qualified by an external enable monitor.

Top module: `flash_pe_interlock`

## Requirements
- R1: After master reset the control word reads 0, the pulse request is 0 and the page-valid flag is 0.
- R2: The control word layout is: bit 0 erase select (0 program, 1 erase), bit 1 sequence active, bit 2 high-voltage enable, bit 3 interrupt enable, bit 4 configuration select, bit 5 protect, bits 13:6 block select, bits 16:14 clock divider, bits 18:17 pulse exponent, bits 25:19 pulse count. A read returns the current word, and a write with the sequence bit clear updates every field except the high-voltage enable.
- R3: While the sequence bit is 1, register writes leave unchanged the erase select, configuration select, protect, block select, clock divider, pulse exponent and pulse count fields.
- R4: The interrupt enable is write-locked only while the sequence bit is 1 and program is selected; in erase mode it stays writable.
- R5: The sequence bit ignores register writes while the high-voltage enable or the high-voltage status input is 1.
- R6: Writing 1 to the high-voltage enable takes effect only if the sequence bit is 1 before and after that write and a qualifying array write was accepted at an earlier clock edge since the sequence began. An array write in the same cycle as the enabling register write does not count. Writing 0 always clears the enable.
- R7: An array write qualifies when the sequence bit is 1 and the enable is 0. In program mode it also produces a same-cycle buffer write whose slot is {address bits 15:12, address bits 3:0} and whose data is the write data. The array address is a word address: bits 3:0 select the word, bits 11:4 the page offset and bits 15:12 the bank.
- R8: The first programming write in a sequence latches address bits 11:4 as the page offset and sets page-valid. Later writes leave the offset unchanged. Page-valid clears at any clock edge at which the sequence bit is 0.
- R9: While the enable is 1, array writes make no buffer write and array reads are not acknowledged. Otherwise a read is acknowledged in the same cycle.
- R10: System reset or stop clears the high-voltage enable at the next edge, overriding a register write, and leaves all other bits unchanged.
- R11: The pulse request equals the high-voltage enable ANDed with the enable-monitor input.
- R12: Each 0-to-1 transition of the sequence bit forgets earlier qualifying writes, so a new sequence needs a fresh array write before the enable can be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, asynchronous active low |
| sys_rst_i | input | 1 | System reset, clears high-voltage enable |
| stop_i | input | 1 | Stop request, clears high-voltage enable |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 26 | Control word write data |
| ctl_rdata_o | output | 26 | Current control word |
| hv_status_i | input | 1 | High-voltage operation in progress |
| pe_mon_i | input | 1 | External enable monitor |
| arr_wr_i | input | 1 | Snooped write to the array range |
| arr_addr_i | input | 16 | Array word address |
| arr_wdata_i | input | 32 | Snooped write data |
| arr_rd_i | input | 1 | Array read request |
| arr_rd_ack_o | output | 1 | Array read acknowledge |
| buf_we_o | output | 1 | Page-buffer write strobe |
| buf_slot_o | output | 8 | Page-buffer slot {bank, word} |
| buf_data_o | output | 32 | Page-buffer write data |
| page_off_o | output | 8 | Latched page offset |
| page_valid_o | output | 1 | Page offset latched in this sequence |
| hv_req_o | output | 1 | High-voltage pulse request |

## Verification
The interlock write and the register write that tries to raise the high-voltage enable can fall in the same clock cycle. The directed part of the bench provokes this with the very first erase interlock write of a sequence. It expects the enable to stay 0 for that cycle and to rise only on a later enabling write. Random stimulus often overlaps register writes, array writes, status, stop and system reset in one cycle. Every cycle is compared against a bench model that applies the requirement rules to the pre-edge state.

// File: rtl/flash_ilk_pkg.sv
package flash_ilk_pkg;
  localparam int BLK_SEL_W = 8;
  localparam int CDIV_W    = 3;
  localparam int PEXP_W    = 2;
  localparam int PCNT_W    = 7;
  localparam int CTL_W     = 6 + BLK_SEL_W + CDIV_W + PEXP_W + PCNT_W;

  typedef struct packed {
    logic [PCNT_W-1:0]    pcnt;
    logic [PEXP_W-1:0]    pexp;
    logic [CDIV_W-1:0]    cdiv;
    logic [BLK_SEL_W-1:0] blk;
    logic                 prot;
    logic                 csel;
    logic                 ien;
    logic                 hv;
    logic                 seq;
    logic                 erase;
  } ctl_t;
endpackage

// File: rtl/flash_ctl_reg.sv
module flash_ctl_reg
  import flash_ilk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en_i,
  input  ctl_t wdata_i,
  input  logic hv_status_i,
  input  logic seen_i,
  input  logic hv_kill_i,
  output ctl_t ctl_o,
  output logic seq_rise_o
);
  ctl_t ctl_q, ctl_d;
  logic ctl_en;

  assign ctl_en = wr_en_i | hv_kill_i;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en_i) begin
      if (!ctl_q.seq) begin
        ctl_d.erase = wdata_i.erase;
        ctl_d.csel  = wdata_i.csel;
        ctl_d.prot  = wdata_i.prot;
        ctl_d.blk   = wdata_i.blk;
        ctl_d.cdiv  = wdata_i.cdiv;
        ctl_d.pexp  = wdata_i.pexp;
        ctl_d.pcnt  = wdata_i.pcnt;
      end
      if (!(ctl_q.seq && !ctl_q.erase)) ctl_d.ien = wdata_i.ien;
      if (!ctl_q.hv && !hv_status_i) ctl_d.seq = wdata_i.seq;
      ctl_d.hv = wdata_i.hv && (ctl_q.hv || (ctl_q.seq && ctl_d.seq && seen_i));
    end
    if (hv_kill_i) ctl_d.hv = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  assign ctl_o      = ctl_q;
  assign seq_rise_o = ~ctl_q.seq & ctl_d.seq;

  // R3: erase select frozen while a sequence is active
  a_r3_erase_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.seq |=> ctl_q.erase == $past(ctl_q.erase));
  // R5: sequence bit frozen under high voltage
  a_r5_seq_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.hv || hv_status_i) |=> ctl_q.seq == $past(ctl_q.seq));
  // R6: enable rises only inside a sequence with a seen write
  a_r6_hv_needs_seen: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q.hv) |-> ($past(ctl_q.seq) && $past(seen_i)));
  // R10: system reset / stop drop the enable
  a_r10_kill_hv: assert property (@(posedge clk) disable iff (!rst_n)
    hv_kill_i |=> !ctl_q.hv);
endmodule

// File: rtl/flash_arr_snoop.sv
module flash_arr_snoop #(
  parameter int WORD_W = 4,
  parameter int PAGE_W = 8,
  parameter int BANK_W = 4,
  parameter int DATA_W = 32,
  localparam int ADDR_W = WORD_W + PAGE_W + BANK_W,
  localparam int SLOT_W = BANK_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_i,
  input  logic              erase_i,
  input  logic              hv_i,
  input  logic              seq_rise_i,
  input  logic              arr_wr_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  input  logic [DATA_W-1:0] arr_wdata_i,
  input  logic              arr_rd_i,
  output logic              arr_rd_ack_o,
  output logic              seen_o,
  output logic              buf_we_o,
  output logic [SLOT_W-1:0] buf_slot_o,
  output logic [DATA_W-1:0] buf_data_o,
  output logic [PAGE_W-1:0] page_off_o,
  output logic              page_valid_o
);
  localparam int PAGE_LSB = WORD_W;
  localparam int BANK_LSB = WORD_W + PAGE_W;

  logic              arr_ok, prog_ok;
  logic              seen_q, seen_d, pv_q, pv_d, st_en;
  logic [PAGE_W-1:0] poff_q, poff_d;

  assign arr_ok  = seq_i & ~hv_i & arr_wr_i;
  assign prog_ok = arr_ok & ~erase_i;

  always_comb begin
    seen_d = seen_q;
    pv_d   = pv_q;
    poff_d = poff_q;
    if (seq_rise_i)  seen_d = 1'b0;
    else if (arr_ok) seen_d = 1'b1;
    if (prog_ok && !pv_q) begin
      pv_d   = 1'b1;
      poff_d = arr_addr_i[PAGE_LSB +: PAGE_W];
    end else if (!seq_i) begin
      pv_d = 1'b0;
    end
  end

  assign st_en = seq_rise_i | arr_ok | ~seq_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      pv_q   <= 1'b0;
      poff_q <= '0;
    end else if (st_en) begin
      seen_q <= seen_d;
      pv_q   <= pv_d;
      poff_q <= poff_d;
    end
  end

  assign seen_o       = seen_q;
  assign page_valid_o = pv_q;
  assign page_off_o   = poff_q;
  assign buf_we_o     = prog_ok;
  assign buf_slot_o   = {arr_addr_i[BANK_LSB +: BANK_W], arr_addr_i[0 +: WORD_W]};
  assign buf_data_o   = arr_wdata_i;
  assign arr_rd_ack_o = arr_rd_i & ~hv_i;

  // R8: offset held once latched in a sequence
  a_r8_offset_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q && seq_i) |=> (pv_q && poff_q == $past(poff_q)));
  // R7: a write is only recorded inside a sequence
  a_r7_seen_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seen_q) |-> $past(seq_i));
endmodule

// File: rtl/flash_pe_interlock.sv
module flash_pe_interlock
  import flash_ilk_pkg::*;
#(
  parameter int WORD_W     = 4,
  parameter int PAGE_W     = 8,
  parameter int BANK_W     = 4,
  parameter int DATA_W     = 32,
  parameter int RST_STAGES = 2,
  localparam int ADDR_W = WORD_W + PAGE_W + BANK_W,
  localparam int SLOT_W = BANK_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_rst_i,
  input  logic              stop_i,
  input  logic              ctl_wr_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  output logic [CTL_W-1:0]  ctl_rdata_o,
  input  logic              hv_status_i,
  input  logic              pe_mon_i,
  input  logic              arr_wr_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  input  logic [DATA_W-1:0] arr_wdata_i,
  input  logic              arr_rd_i,
  output logic              arr_rd_ack_o,
  output logic              buf_we_o,
  output logic [SLOT_W-1:0] buf_slot_o,
  output logic [DATA_W-1:0] buf_data_o,
  output logic [PAGE_W-1:0] page_off_o,
  output logic              page_valid_o,
  output logic              hv_req_o
);
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_int_n;
  ctl_t                  ctl, wdata;
  logic                  seen, seq_rise;

  generate
    if (RST_STAGES == 1) begin : g_rs1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= 1'b1;
      end
    end else begin : g_rsn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
      end
    end
  endgenerate
  assign rst_int_n = rst_sync_q[RST_STAGES-1];

  assign wdata = ctl_t'(ctl_wdata_i);

  flash_ctl_reg i_reg (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en_i    (ctl_wr_i),
    .wdata_i    (wdata),
    .hv_status_i(hv_status_i),
    .seen_i     (seen),
    .hv_kill_i  (sys_rst_i | stop_i),
    .ctl_o      (ctl),
    .seq_rise_o (seq_rise)
  );

  flash_arr_snoop #(
    .WORD_W(WORD_W), .PAGE_W(PAGE_W), .BANK_W(BANK_W), .DATA_W(DATA_W)
  ) i_snoop (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .seq_i       (ctl.seq),
    .erase_i     (ctl.erase),
    .hv_i        (ctl.hv),
    .seq_rise_i  (seq_rise),
    .arr_wr_i    (arr_wr_i),
    .arr_addr_i  (arr_addr_i),
    .arr_wdata_i (arr_wdata_i),
    .arr_rd_i    (arr_rd_i),
    .arr_rd_ack_o(arr_rd_ack_o),
    .seen_o      (seen),
    .buf_we_o    (buf_we_o),
    .buf_slot_o  (buf_slot_o),
    .buf_data_o  (buf_data_o),
    .page_off_o  (page_off_o),
    .page_valid_o(page_valid_o)
  );

  assign ctl_rdata_o = ctl;
  assign hv_req_o    = ctl.hv & pe_mon_i;

  // R9: no buffer write and no read acknowledge while a pulse is requested
  a_r9_hv_blocks: assert property (@(posedge clk) disable iff (!rst_int_n)
    hv_req_o |-> (!buf_we_o && !arr_rd_ack_o));
endmodule

// File: tb/test_flash_pe_interlock.sv
module test_flash_pe_interlock;
  localparam int CLK_P = 10;
  localparam int NRAND = 4000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sys_rst, stop, ctl_wr, hv_status, pe_mon, arr_wr, arr_rd;
  logic [25:0] ctl_wdata, ctl_rdata;
  logic [15:0] arr_addr;
  logic [31:0] arr_wdata, buf_data;
  logic        arr_rd_ack, buf_we, page_valid, hv_req;
  logic [7:0]  buf_slot, page_off;

  int checks = 0;
  int fails  = 0;

  logic [25:0] m_reg;
  logic        m_seen, m_pv;
  logic [7:0]  m_poff;

  always #(CLK_P/2) clk = ~clk;

  flash_pe_interlock i_flash_pe_interlock (
    .clk(clk), .rst_n(rst_n), .sys_rst_i(sys_rst), .stop_i(stop),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata),
    .hv_status_i(hv_status), .pe_mon_i(pe_mon),
    .arr_wr_i(arr_wr), .arr_addr_i(arr_addr), .arr_wdata_i(arr_wdata),
    .arr_rd_i(arr_rd), .arr_rd_ack_o(arr_rd_ack),
    .buf_we_o(buf_we), .buf_slot_o(buf_slot), .buf_data_o(buf_data),
    .page_off_o(page_off), .page_valid_o(page_valid), .hv_req_o(hv_req)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_slot(input logic [15:0] a);
    return {a[15:12], a[3:0]};
  endfunction

  // one clock: drive at negedge, compare before the edge, advance model at the edge
  task automatic step(input logic wr, input logic [25:0] wd, input logic aw, input logic [15:0] ad,
                      input logic rd, input logic hvs, input logic sr, input logic stp, input logic mon);
    logic [25:0] nxt;
    logic        seq, op, hv, ok_w;
    @(negedge clk);
    ctl_wr = wr; ctl_wdata = wd; arr_wr = aw; arr_addr = ad; arr_wdata = $urandom;
    arr_rd = rd; hv_status = hvs; sys_rst = sr; stop = stp; pe_mon = mon;
    #1;
    seq = m_reg[1]; op = m_reg[0]; hv = m_reg[2];
    ok_w = seq && !hv && aw;
    chk(ctl_rdata == m_reg, "R2 control word", 32'(ctl_rdata), 32'(m_reg));
    chk(hv_req == (hv && mon), "R11 pulse request", 32'(hv_req), 32'(hv && mon));
    chk(arr_rd_ack == (rd && !hv), "R9 read ack", 32'(arr_rd_ack), 32'(rd && !hv));
    chk(buf_we == (ok_w && !op), "R7 buffer write", 32'(buf_we), 32'(ok_w && !op));
    if (ok_w && !op) begin
      chk(buf_slot == exp_slot(ad), "R7 buffer slot", 32'(buf_slot), 32'(exp_slot(ad)));
      chk(buf_data == arr_wdata, "R7 buffer data", buf_data, arr_wdata);
    end
    chk(page_valid == m_pv, "R8 page valid", 32'(page_valid), 32'(m_pv));
    if (m_pv) chk(page_off == m_poff, "R8 page offset", 32'(page_off), 32'(m_poff));
    @(posedge clk);
    nxt = m_reg;
    if (wr) begin
      if (!seq) begin nxt[0] = wd[0]; nxt[25:4] = wd[25:4]; end
      if (!(seq && !op)) nxt[3] = wd[3];
      if (!hv && !hvs) nxt[1] = wd[1];
      nxt[2] = wd[2] && (hv || (seq && nxt[1] && m_seen));
    end
    if (sr || stp) nxt[2] = 1'b0;
    if (!seq && nxt[1])  m_seen = 1'b0;
    else if (ok_w)       m_seen = 1'b1;
    if (ok_w && !op && !m_pv) begin m_pv = 1'b1; m_poff = ad[11:4]; end
    else if (!seq)            m_pv = 1'b0;
    m_reg = nxt;
    #1;
  endtask

  task automatic wr_ctl(input logic [25:0] wd);
    step(1'b1, wd, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic idle();
    step(1'b0, 26'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin : watchdog
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; ctl_wr = 0; ctl_wdata = '0; arr_wr = 0; arr_addr = '0; arr_wdata = '0;
    arr_rd = 0; hv_status = 0; sys_rst = 0; stop = 0; pe_mon = 0;
    m_reg = '0; m_seen = 0; m_pv = 0; m_poff = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(ctl_rdata == 26'h0, "R1 word after reset", 32'(ctl_rdata), 0);
    chk(hv_req == 1'b0, "R1 request after reset", 32'(hv_req), 0);
    chk(page_valid == 1'b0, "R1 page valid after reset", 32'(page_valid), 0);

    wr_ctl(26'h3FF_FFF9); #1;
    chk(ctl_rdata == 26'h3FF_FFF9, "R2 open write", 32'(ctl_rdata), 32'h3FF_FFF9);
    wr_ctl(26'h3);
    wr_ctl(26'h3FF_FFFA); #1;
    chk(ctl_rdata == 26'hB, "R3 R4 locked fields, erase ien free", 32'(ctl_rdata), 32'hB);
    wr_ctl(26'hF); #1;
    chk(ctl_rdata[2] == 1'b0, "R6 no interlock write yet", 32'(ctl_rdata[2]), 0);
    // R6: first interlock write and enabling write in the same cycle
    step(1'b1, 26'hF, 1'b1, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1); #1;
    chk(ctl_rdata[2] == 1'b0, "R6 same-cycle interlock not counted", 32'(ctl_rdata[2]), 0);
    wr_ctl(26'hF); #1;
    chk(ctl_rdata == 26'hF, "R6 enable after interlock", 32'(ctl_rdata), 32'hF);
    step(1'b1, 26'hD, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); #1;
    chk(ctl_rdata[1] == 1'b1, "R5 sequence held under enable", 32'(ctl_rdata[1]), 1);
    chk(hv_req == 1'b0, "R11 monitor low masks request", 32'(hv_req), 0);
    chk(arr_rd_ack == 1'b0, "R9 read refused under enable", 32'(arr_rd_ack), 0);
    step(1'b1, 26'hF, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1); #1;
    chk(ctl_rdata == 26'hB, "R10 stop beats write", 32'(ctl_rdata), 32'hB);
    wr_ctl(26'h8);
    wr_ctl(26'hB);
    wr_ctl(26'hF); #1;
    chk(ctl_rdata[2] == 1'b0, "R12 new sequence forgets interlock", 32'(ctl_rdata[2]), 0);
    wr_ctl(26'h8);
    wr_ctl(26'h0);
    wr_ctl(26'hA);
    wr_ctl(26'h2); #1;
    chk(ctl_rdata[3] == 1'b1, "R4 ien locked in program", 32'(ctl_rdata[3]), 1);
    step(1'b0, 26'h0, 1'b1, 16'h53C9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1); #1;
    chk(page_off == 8'h3C && page_valid, "R8 first write latches offset", 32'(page_off), 32'h3C);
    step(1'b0, 26'h0, 1'b1, 16'h2113, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1); #1;
    chk(page_off == 8'h3C, "R8 later write keeps offset", 32'(page_off), 32'h3C);
    wr_ctl(26'hE);
    step(1'b0, 26'h0, 1'b1, 16'h0777, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1); #1;
    chk(buf_we == 1'b0, "R9 program write dropped under enable", 32'(buf_we), 0);
    step(1'b0, 26'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1); #1;
    chk(ctl_rdata == 26'hA, "R10 system reset drops only enable", 32'(ctl_rdata), 32'hA);
    wr_ctl(26'h8);
    idle(); #1;
    chk(page_valid == 1'b0, "R8 release after sequence end", 32'(page_valid), 0);

    for (int i = 0; i < NRAND; i++) begin
      logic [25:0] wd;
      wd = 26'($urandom);
      wd[1] = ($urandom % 4) != 0;
      step(($urandom % 10) < 3, wd, ($urandom % 10) < 3, 16'($urandom),
           ($urandom % 10) < 3, ($urandom % 20) == 0, ($urandom % 50) == 0,
           ($urandom % 50) == 0, ($urandom % 10) < 7);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule